// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Arithmetic Unit

This block is the arithmetic core of a small 16-bit signal processor. Every value is a two's-complement fraction. It holds four 16-bit operand registers and two 40-bit accumulators. Each accumulator is a 32-bit fraction with 8 guard bits above it, so a run of accumulations can exceed the unit range without losing the sign. One shared adder serves every operation. A product, the other accumulator or a divisor feeds one of its inputs, and the destination accumulator feeds the other. Rounding, the one-bit shifts of division and normalization, and product scaling all sit between the adder and the accumulator registers.

A sequencer outside the block issues one operation per cycle. It gives an opcode, two operand selects and a destination select. In the same cycle it can load one operand register from a data bus. The operation reads the operand values from before that load. Each accumulator is always visible as a 16-bit word for the data buses. That word saturates when the guard bits show the value has left the 16-bit fractional range. A multi-step division or normalization is built in firmware by issuing the single step repeatedly.

Top module: `frac_mac_unit`

## Requirements
- R1: After reset both accumulators, all four operand registers and the normalization count are zero, so both bus words read 0x0000 and the count reads 0.
- R2: When `ldEn` is high, the register picked by `ldSel` takes `ldData` at the clock edge. Register codes are 0=X0, 1=X1, 2=Y0, 3=Y1. `srcSelA` and `srcSelB` use the same codes for the two multiplier inputs and may name the same register, which squares it.
- R3: Opcode 1 writes the product into the destination. The product is the signed 16x16 product shifted left by one and sign-extended to 40 bits. The one exception is 0x8000 times 0x8000, which gives 0x00_7FFF_FFFF.
- R4: Opcode 3 adds that product to the destination with 40-bit wraparound. The guard bits keep values beyond the 32-bit range, so later accumulations can bring the value back into range without error.
- R5: Rounding adds 0x8000 to the 40-bit value and then clears bits 15..0. Opcode 2 rounds the product of opcode 1, opcode 4 rounds the sum of opcode 3, and opcode 5 rounds the destination in place.
- R6: Opcode 6 sets destination = destination + other accumulator. Opcode 7 sets destination = destination - other accumulator. Opcode 8 negates the destination. Opcode 9 replaces the destination with its absolute value. All four are 40-bit two's-complement operations.
- R7: Opcode 10 is one division step, with the divisor D taken from the register named by `srcSelA`. Let q = NOT(bit 39 of destination XOR sign of D). The destination shifts left one with q entering bit 0. The step then subtracts D placed at bits 31..16 (sign-extended) if q is 1, and adds it if q is 0.
- R8: Opcode 11 is one normalization step. If bits 31 and 30 of the destination are equal, the destination shifts left one and the 6-bit count decrements, wrapping modulo 64. Otherwise nothing changes. No other operation changes the count.
- R9: Each bus word is bits 31..16 of its accumulator when bits 39..31 are all equal. Otherwise it is 0x7FFF for a positive accumulator and 0x8000 for a negative one. `busA` shows accumulator A and `busB` shows accumulator B.
- R10: `dstSel` picks the destination, 0 for A and 1 for B. The other accumulator never changes. Opcodes 0 and 12..15, or `opValid` low, leave both accumulators and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 4 | Operation code |
| srcSelA | input | 2 | First multiplier operand / divisor select |
| srcSelB | input | 2 | Second multiplier operand select |
| dstSel | input | 1 | Destination accumulator (0=A, 1=B) |
| ldEn | input | 1 | Operand register load enable |
| ldSel | input | 2 | Operand register to load |
| ldData | input | 16 | Operand load data |
| busA | output | 16 | Saturated read of accumulator A |
| busB | output | 16 | Saturated read of accumulator B |
| normCount | output | 6 | Normalization count |

## Verification
The hardest state to reach from the ports is a value that sits in the guard bits. Only saturated 16-bit words are visible, so the guard bits can only be seen indirectly. The stimulus squares 0x8000 and accumulates that product a second time, which drives the value past 32 bits. It then subtracts large products until the value returns to range, where a correct 40-bit accumulator reads 0x0001 again. Random sequences of loads and all opcodes are biased toward the extreme operand values 0x8000 and 0x7FFF. Their additions and subtractions between accumulators repeatedly cross the saturation boundary. Division and normalization steps are issued as chains, so the quotient bits and the count build up over several cycles.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  typedef enum logic [2:0] {
    K_MUL  = 3'd0,
    K_RND  = 3'd1,
    K_ADD  = 3'd2,
    K_SUB  = 3'd3,
    K_NEG  = 3'd4,
    K_ABS  = 3'd5,
    K_DIV  = 3'd6,
    K_NORM = 3'd7
  } kind_e;

  typedef struct packed {
    logic  write;
    kind_e kind;
    logic  accum;
    logic  round;
  } strobe_t;

  localparam logic [3:0] OP_MPY  = 4'd1;
  localparam logic [3:0] OP_MPYR = 4'd2;
  localparam logic [3:0] OP_MAC  = 4'd3;
  localparam logic [3:0] OP_MACR = 4'd4;
  localparam logic [3:0] OP_RND  = 4'd5;
  localparam logic [3:0] OP_ADD  = 4'd6;
  localparam logic [3:0] OP_SUB  = 4'd7;
  localparam logic [3:0] OP_NEG  = 4'd8;
  localparam logic [3:0] OP_ABS  = 4'd9;
  localparam logic [3:0] OP_DIV  = 4'd10;
  localparam logic [3:0] OP_NORM = 4'd11;

endpackage

// File: rtl/frac_mac_ctrl.sv
module frac_mac_ctrl
  import frac_mac_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output strobe_t    strb
);

  always_comb begin
    strb       = '0;
    strb.kind  = K_MUL;
    if (opValid) begin
      strb.write = 1'b1;
      case (opCode)
        OP_MPY:  strb.kind = K_MUL;
        OP_MPYR: begin strb.kind = K_MUL; strb.round = 1'b1; end
        OP_MAC:  begin strb.kind = K_MUL; strb.accum = 1'b1; end
        OP_MACR: begin strb.kind = K_MUL; strb.accum = 1'b1; strb.round = 1'b1; end
        OP_RND:  begin strb.kind = K_RND; strb.round = 1'b1; end
        OP_ADD:  strb.kind = K_ADD;
        OP_SUB:  strb.kind = K_SUB;
        OP_NEG:  strb.kind = K_NEG;
        OP_ABS:  strb.kind = K_ABS;
        OP_DIV:  strb.kind = K_DIV;
        OP_NORM: strb.kind = K_NORM;
        default: strb.write = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/frac_mac_datapath.sv
module frac_mac_datapath
  import frac_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 6,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [1:0]                srcSelA,
  input  logic [1:0]                srcSelB,
  input  logic                      dstSel,
  input  logic                      ldEn,
  input  logic [1:0]                ldSel,
  input  logic [DATA_W-1:0]         ldData,
  output logic [1:0][ACC_W-1:0]     accQ,
  output logic [CNT_W-1:0]          normCnt
);

  localparam logic [DATA_W-1:0] MIN_FRAC = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] MAX_PROD = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  RND_HALF = ACC_W'(1) << (DATA_W - 1);
  localparam logic [ACC_W-1:0]  RND_MASK = {{(ACC_W-DATA_W){1'b1}}, {DATA_W{1'b0}}};

  logic [3:0][DATA_W-1:0] opReg;
  logic [DATA_W-1:0]      opA, opB;
  logic [PROD_W-1:0]      opAx, opBx, prodRaw, prodSh;
  logic [ACC_W-1:0]       prodExt, divExt, accCur, accOth, shifted, sumVal, resVal;
  logic                   qBit, normDo;

  // operand selection and fractional product
  assign opA     = opReg[srcSelA];
  assign opB     = opReg[srcSelB];
  assign opAx    = {{DATA_W{opA[DATA_W-1]}}, opA};
  assign opBx    = {{DATA_W{opB[DATA_W-1]}}, opB};
  assign prodRaw = opAx * opBx;
  assign prodSh  = (opA == MIN_FRAC && opB == MIN_FRAC) ? MAX_PROD : (prodRaw << 1);
  assign prodExt = {{GUARD_W{prodSh[PROD_W-1]}}, prodSh};
  assign divExt  = {{GUARD_W{opA[DATA_W-1]}}, opA, {DATA_W{1'b0}}};

  assign accCur  = accQ[dstSel];
  assign accOth  = accQ[~dstSel];

  // adder and post-adder stage
  always_comb begin
    qBit    = ~(accCur[ACC_W-1] ^ opA[DATA_W-1]);
    shifted = {accCur[ACC_W-2:0], qBit};
    normDo  = (accCur[PROD_W-1] == accCur[PROD_W-2]);
    case (strb.kind)
      K_MUL:   sumVal = strb.accum ? accCur + prodExt : prodExt;
      K_RND:   sumVal = accCur;
      K_ADD:   sumVal = accCur + accOth;
      K_SUB:   sumVal = accCur - accOth;
      K_NEG:   sumVal = -accCur;
      K_ABS:   sumVal = accCur[ACC_W-1] ? -accCur : accCur;
      K_DIV:   sumVal = qBit ? shifted - divExt : shifted + divExt;
      K_NORM:  sumVal = normDo ? {accCur[ACC_W-2:0], 1'b0} : accCur;
      default: sumVal = accCur;
    endcase
    resVal = strb.round ? ((sumVal + RND_HALF) & RND_MASK) : sumVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      accQ    <= '0;
      normCnt <= '0;
    end else begin
      if (ldEn) opReg[ldSel] <= ldData;
      if (strb.write) begin
        accQ[dstSel] <= resVal;
        if (strb.kind == K_NORM && normDo) normCnt <= normCnt - 1'b1;
      end
    end
  end

  AST_ACC_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write && !dstSel) |=> $stable(accQ[0])); // R10
  AST_ACC_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write && dstSel) |=> $stable(accQ[1])); // R10
  AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && strb.kind == K_MUL && !strb.accum && !strb.round &&
     opA == MIN_FRAC && opB == MIN_FRAC)
    |=> accQ[$past(dstSel)] == {{GUARD_W{1'b0}}, MAX_PROD}); // R3
  AST_ROUND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && strb.round) |=> accQ[$past(dstSel)][DATA_W-1:0] == '0); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.write && strb.kind == K_NORM) |=> $stable(normCnt)); // R8

endmodule

// File: rtl/frac_mac_sat.sv
module frac_mac_sat #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic [ACC_W-1:0]  accIn,
  output logic [DATA_W-1:0] busOut
);

  logic inRange;

  assign inRange = (&accIn[ACC_W-1:PROD_W-1]) | ~(|accIn[ACC_W-1:PROD_W-1]);
  assign busOut  = inRange ? accIn[PROD_W-1:DATA_W]
                           : {accIn[ACC_W-1], {(DATA_W-1){~accIn[ACC_W-1]}}};

endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit
  import frac_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        srcSelA,
  input  logic [1:0]        srcSelB,
  input  logic              dstSel,
  input  logic              ldEn,
  input  logic [1:0]        ldSel,
  input  logic [DATA_W-1:0] ldData,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic [CNT_W-1:0]  normCount
);

  localparam int ACC_W = 2 * DATA_W + GUARD_W;

  strobe_t                  strb;
  logic [1:0][ACC_W-1:0]    accQ;
  logic [1:0][DATA_W-1:0]   busQ;

  frac_mac_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  frac_mac_datapath #(
    .DATA_W  (DATA_W),
    .GUARD_W (GUARD_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcSelA (srcSelA),
    .srcSelB (srcSelB),
    .dstSel  (dstSel),
    .ldEn    (ldEn),
    .ldSel   (ldSel),
    .ldData  (ldData),
    .accQ    (accQ),
    .normCnt (normCount)
  );

  for (genvar g = 0; g < 2; g++) begin : g_read
    frac_mac_sat #(
      .DATA_W  (DATA_W),
      .GUARD_W (GUARD_W)
    ) u_sat (
      .accIn  (accQ[g]),
      .busOut (busQ[g])
    );
  end

  assign busA = busQ[0];
  assign busB = busQ[1];

endmodule

// File: tb/frac_mac_unit_test.sv
module frac_mac_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  srcSelA = '0, srcSelB = '0;
  logic        dstSel = 1'b0;
  logic        ldEn = 1'b0;
  logic [1:0]  ldSel = '0;
  logic [15:0] ldData = '0;
  logic [15:0] busA, busB;
  logic [5:0]  normCount;

  int checks = 0;
  int errors = 0;
  bit runDone = 0;

  logic [39:0] mAcc [2];
  logic [15:0] mReg [4];
  logic [5:0]  mCnt;

  frac_mac_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcSelA(srcSelA), .srcSelB(srcSelB), .dstSel(dstSel),
    .ldEn(ldEn), .ldSel(ldSel), .ldData(ldData),
    .busA(busA), .busB(busB), .normCount(normCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [39:0] product(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    if (a == 16'h8000 && b == 16'h8000) return 40'h00_7FFF_FFFF;
    p = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
    p = p <<< 1;
    return {{8{p[31]}}, p};
  endfunction

  function automatic logic [39:0] rounded(input logic [39:0] v);
    return (v + 40'h8000) & ~40'hFFFF;
  endfunction

  function automatic logic [15:0] readWord(input logic [39:0] v);
    if (v[39:31] == 9'h000 || v[39:31] == 9'h1FF) return v[31:16];
    return v[39] ? 16'h8000 : 16'h7FFF;
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1, 4'd2:             return "R3";
      4'd3, 4'd4:             return "R4";
      4'd5:                   return "R5";
      4'd6, 4'd7, 4'd8, 4'd9: return "R6";
      4'd10:                  return "R7";
      4'd11:                  return "R8";
      default:                return "R10";
    endcase
  endfunction

  task automatic modelOp(input logic [3:0] op, input logic [1:0] sa,
                         input logic [1:0] sb, input logic d);
    logic [39:0] cur, oth, r, dv, sh;
    logic q;
    cur = mAcc[d];
    oth = mAcc[!d];
    r   = cur;
    case (op)
      4'd1:  r = product(mReg[sa], mReg[sb]);
      4'd2:  r = rounded(product(mReg[sa], mReg[sb]));
      4'd3:  r = cur + product(mReg[sa], mReg[sb]);
      4'd4:  r = rounded(cur + product(mReg[sa], mReg[sb]));
      4'd5:  r = rounded(cur);
      4'd6:  r = cur + oth;
      4'd7:  r = cur - oth;
      4'd8:  r = -cur;
      4'd9:  r = cur[39] ? -cur : cur;
      4'd10: begin
        dv = {{8{mReg[sa][15]}}, mReg[sa], 16'h0000};
        q  = ~(cur[39] ^ mReg[sa][15]);
        sh = {cur[38:0], q};
        r  = q ? sh - dv : sh + dv;
      end
      4'd11: if (cur[31] == cur[30]) begin
        r = {cur[38:0], 1'b0};
        mCnt = mCnt - 6'd1;
      end
      default: r = cur;
    endcase
    mAcc[d] = r;
  endtask

  task automatic checkState(input string tag);
    logic [37:0] act, exp;
    act = {busA, busB, normCount};
    exp = {readWord(mAcc[0]), readWord(mAcc[1]), mCnt};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual busA=%h busB=%h cnt=%0d expected busA=%h busB=%h cnt=%0d",
               tag, busA, busB, normCount, exp[37:22], exp[21:6], exp[5:0]);
    end
  endtask

  // one clock: optional load and optional op; op uses old register values
  task automatic cycle(input logic v, input logic [3:0] op, input logic [1:0] sa,
                       input logic [1:0] sb, input logic d, input logic le,
                       input logic [1:0] ls, input logic [15:0] ld, input string tag);
    @(negedge clk);
    opValid = v; opCode = op; srcSelA = sa; srcSelB = sb; dstSel = d;
    ldEn = le; ldSel = ls; ldData = ld;
    @(posedge clk);
    if (v) modelOp(op, sa, sb, d);
    if (le) mReg[ls] = ld;
    @(negedge clk);
    opValid = 1'b0; ldEn = 1'b0;
    checkState(tag);
  endtask

  task automatic load(input logic [1:0] ls, input logic [15:0] ld);
    cycle(1'b0, 4'd0, 2'd0, 2'd0, 1'b0, 1'b1, ls, ld, "R2");
  endtask

  task automatic doOp(input logic [3:0] op, input logic [1:0] sa, input logic [1:0] sb,
                      input logic d, input string tag);
    cycle(1'b1, op, sa, sb, d, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!runDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  function automatic logic [15:0] pickData();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    mAcc[0] = '0; mAcc[1] = '0; mCnt = '0;
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkState("R1 reset");
    rstN = 1'b1;
    // R1: registers zero, so a square of X0 gives zero
    doOp(4'd1, 2'd0, 2'd0, 1'b0, "R1 operand regs zero");

    // R3: -1 * -1 saturates to largest positive fraction
    load(2'd0, 16'h8000);
    doOp(4'd1, 2'd0, 2'd0, 1'b0, "R3 min square");
    // R9/R5: rounding pushes value to 0x00_8000_0000, bus saturates positive
    doOp(4'd5, 2'd0, 2'd0, 1'b0, "R5 R9 round overflow");
    // R2: squaring Y1
    load(2'd3, 16'h4000);
    doOp(4'd1, 2'd3, 2'd3, 1'b1, "R2 square Y1");
    // R6: negate and absolute value
    doOp(4'd8, 2'd0, 2'd0, 1'b1, "R6 neg");
    doOp(4'd9, 2'd0, 2'd0, 1'b1, "R6 abs");
    // R8: normalization steps
    doOp(4'd11, 2'd0, 2'd0, 1'b1, "R8 norm shift");
    doOp(4'd11, 2'd0, 2'd0, 1'b1, "R8 norm stop");

    // R4: guard bits hold an out-of-range sum and come back
    load(2'd1, 16'h7FFF);
    doOp(4'd1, 2'd0, 2'd0, 1'b0, "R4 start");
    doOp(4'd3, 2'd0, 2'd0, 1'b0, "R4 R9 past 32 bits");
    doOp(4'd3, 2'd0, 2'd1, 1'b0, "R4 still high");
    doOp(4'd3, 2'd0, 2'd1, 1'b0, "R4 back in range");
    checks++;
    if (busA !== 16'h0001) begin
      errors++;
      $display("FAIL R4: actual busA=%h expected busA=0001", busA);
    end

    // R7: chain of division steps
    load(2'd2, 16'h2000);
    load(2'd1, 16'h4000);
    doOp(4'd1, 2'd1, 2'd2, 1'b0, "R7 dividend");
    for (int i = 0; i < 6; i++) doOp(4'd10, 2'd1, 2'd0, 1'b0, "R7 div step");

    // R10: no-op code and strobe low leave state unchanged
    doOp(4'd0, 2'd0, 2'd0, 1'b0, "R10 nop");
    doOp(4'd13, 2'd0, 2'd0, 1'b1, "R10 unused code");
    cycle(1'b0, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0, "R10 strobe low");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] op;
      logic le;
      op = 4'($urandom % 16);
      le = ($urandom % 3) == 0;
      cycle(($urandom % 8) != 0, op, 2'($urandom), 2'($urandom), 1'($urandom),
            le, 2'($urandom), pickData(), reqOf(op));
    end

    runDone = 1;
    finishRun();
  end

endmodule